// File: doc/BRIEF.md
# Serial EEPROM Configuration Autoloader

After reset this block finds out whether a serial EEPROM is fitted. It then reads the EEPROM's image, one 16-bit word at a time, over a three-wire serial link with chip select, serial clock and data. It writes the image bytes into a 16-byte station-address store and a bank of 16-bit configuration registers. It checks an 8-bit checksum over the whole image. The EEPROM serial clock shares its pin with an LED. The block senses that pin while reset is held: a board without an EEPROM pulls the pin low. A failed checksum returns the configuration registers to their reset values, and the station bytes keep what was read.

While the load runs, every host access is turned away with a retry response, so the initiator tries again later. When the load is finished, the host can read the station bytes, the configuration registers and a control/status word on a single-cycle request port. Through that control word the host can also drive the serial pins directly, which lets software read or program the EEPROM bit by bit. The host port has no back-pressure. A request is a one-cycle pulse, and the block always answers it on the following cycle, either with data or with a retry.

Top module: `eel_autoload`

## Requirements
- R1: The sense pin is sampled on the clock edge of the last cycle with rst_n low. A 1 starts the load at the first edge after reset, and ld_busy and ee_cs are then high. A 0 abandons the load: ld_busy is low from the first edge after reset, ld_read and ld_valid stay 0, and ee_cs never rises.
- R2: Each word read holds ee_cs high. It sends a start bit 1, the opcode bits 1 then 0 and a 6-bit word address, MSB first. It then takes 16 data bits, MSB first. ee_cs is low for one bit slot between words. Words 0 to 40 are read in increasing address order, which makes 41 commands.
- R3: One ee_sk period lasts 2*SK_HALF clock cycles: low for SK_HALF cycles, then high for SK_HALF cycles. ee_do is sampled at the rising edge of ee_sk.
- R4: Image byte 2k is the low byte of word k, and byte 2k+1 is its high byte. Bytes 0 to 15 go to the station store, which the host reads at addresses 0 to 15 as {8'h00, byte}. Word 8+j goes to configuration register j, which the host reads at address 16+j. Any other address below 127 reads 0.
- R5: If the 8-bit sum of all 82 bytes equals FFh, ld_read and ld_valid both go to 1. Both flags then hold until the next reset.
- R6: If the checksum fails, ld_read goes to 1 and ld_valid to 0. Every configuration register returns to its reset value, and the station bytes keep the loaded data.
- R7: A request made while ld_busy is high gets host_devsel=1, host_stop=1 and host_trdy=0 on the next cycle. A write made then has no effect.
- R8: A request made while ld_busy is low gets host_devsel=1, host_trdy=1 and host_stop=0 on the next cycle, with the read data. A cycle without a request is followed by host_devsel=0.
- R9: The control word at address 127 has these bits: bit 0 chip select, bit 1 clock, bit 2 data-in, bit 3 live ee_do, bit 4 direct enable, bit 14 ld_read and bit 15 ld_valid. A host write sets bits 0, 1, 2 and 4. While idle with bit 4 set, ee_cs, ee_sk and ee_di follow bits 0 to 2 from the cycle after the write. With bit 4 clear, those pins are 0.
- R10: Configuration register j resets to 16'h5A00 | j. After a load with no EEPROM present, the registers read back these values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ee_sense | input | 1 | Level of the shared clock/LED pin, sensed during reset |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data to the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |
| host_req | input | 1 | One-cycle access request |
| host_wr | input | 1 | Request is a write |
| host_addr | input | 7 | Access address |
| host_wdata | input | 16 | Write data |
| host_devsel | output | 1 | Access claimed |
| host_trdy | output | 1 | Access completed |
| host_stop | output | 1 | Access must be retried |
| host_rdata | output | 16 | Read data |
| ld_busy | output | 1 | Detection or load in progress |
| ld_read | output | 1 | An image was read in full |
| ld_valid | output | 1 | The image checksum passed |

## Verification
The assertions assume that host_req is a single-cycle pulse with address and write data valid in that cycle. They also assume that ee_do has a defined level whenever the serial clock rises. The bench drives every request for exactly one cycle, changing inputs on the falling clock edge. Its EEPROM model changes ee_do only on falling edges of ee_sk while chip select is high, and drives it low between commands. The sense pin is moved only while reset is held, including a change placed just before the final reset edge.

// File: rtl/eel_pkg.sv
package eel_pkg;
  localparam logic [2:0] READ_CMD = 3'b110;

  localparam int unsigned CB_CS    = 0;
  localparam int unsigned CB_SK    = 1;
  localparam int unsigned CB_DI    = 2;
  localparam int unsigned CB_DO    = 3;
  localparam int unsigned CB_EN    = 4;
  localparam int unsigned CB_READ  = 14;
  localparam int unsigned CB_VALID = 15;

  typedef enum logic [1:0] {
    LD_BOOT,
    LD_LOAD,
    LD_CHECK,
    LD_IDLE
  } ld_state_e;

  // Reset value of configuration register idx
  function automatic logic [15:0] cfg_default(input int unsigned idx);
    return 16'h5A00 | 16'(idx & 32'hFF);
  endfunction
endpackage

// File: rtl/eel_serial.sv
module eel_serial #(
  parameter int unsigned SK_HALF = 2,
  parameter int unsigned AW      = 6,
  parameter int unsigned DW      = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr,
  input  logic          sdo,
  output logic          sk,
  output logic          cs,
  output logic          sdi,
  output logic          done,
  output logic [DW-1:0] word
);
  import eel_pkg::*;

  localparam int unsigned CMD_BITS = 3 + AW;
  localparam int unsigned GAP_SLOT = CMD_BITS + DW;
  localparam int unsigned SLW      = $clog2(GAP_SLOT + 1);
  localparam int unsigned HCW      = (SK_HALF > 1) ? $clog2(SK_HALF) : 1;

  logic                run_q;
  logic                phase_q;
  logic                done_q;
  logic [SLW-1:0]      slot_q;
  logic [HCW-1:0]      hcnt_q;
  logic [CMD_BITS-1:0] cmd_q;
  logic [DW-1:0]       shr_q;
  logic                half_end;
  logic                in_data;

  assign half_end = (hcnt_q == HCW'(SK_HALF - 1));
  assign in_data  = (slot_q >= SLW'(CMD_BITS)) && (slot_q < SLW'(GAP_SLOT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      phase_q <= 1'b0;
      done_q  <= 1'b0;
      slot_q  <= '0;
      hcnt_q  <= '0;
      cmd_q   <= '0;
      shr_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run_q) begin
        if (start) begin
          run_q   <= 1'b1;
          slot_q  <= '0;
          hcnt_q  <= '0;
          phase_q <= 1'b0;
          cmd_q   <= {READ_CMD, addr};
        end
      end else if (!half_end) begin
        hcnt_q <= hcnt_q + 1'b1;
      end else begin
        hcnt_q <= '0;
        if (!phase_q) begin
          // rising serial clock: capture returned data
          phase_q <= 1'b1;
          if (in_data) shr_q <= {shr_q[DW-2:0], sdo};
        end else begin
          // falling serial clock: advance to next bit slot
          phase_q <= 1'b0;
          cmd_q   <= {cmd_q[CMD_BITS-2:0], 1'b0};
          if (slot_q == SLW'(GAP_SLOT)) begin
            run_q  <= 1'b0;
            done_q <= 1'b1;
          end else begin
            slot_q <= slot_q + 1'b1;
          end
        end
      end
    end
  end

  assign sk   = run_q & phase_q;
  assign cs   = run_q && (slot_q != SLW'(GAP_SLOT));
  assign sdi  = run_q && (slot_q < SLW'(CMD_BITS)) && cmd_q[CMD_BITS-1];
  assign done = done_q;
  assign word = shr_q;
endmodule

// File: rtl/eel_image.sv
module eel_image #(
  parameter int unsigned ADDR_BYTES = 16,
  parameter int unsigned CFG_REGS   = 33,
  parameter int unsigned WIW        = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [WIW-1:0]               wr_idx,
  input  logic [15:0]                  wr_word,
  input  logic                         restore,
  output logic [ADDR_BYTES-1:0][7:0]   station,
  output logic [CFG_REGS-1:0][15:0]    cfg,
  output logic [7:0]                   sum
);
  import eel_pkg::*;

  localparam int unsigned ADDR_WORDS = ADDR_BYTES / 2;

  logic [ADDR_BYTES-1:0][7:0] station_q;
  logic [CFG_REGS-1:0][15:0]  cfg_q;
  logic [7:0]                 sum_q;

  // Station bytes are not reset: their content is undefined until loaded
  always_ff @(posedge clk) begin
    for (int b = 0; b < int'(ADDR_BYTES); b++) begin
      if (wr_en && wr_idx == WIW'(b / 2)) begin
        station_q[b] <= (b % 2 == 0) ? wr_word[7:0] : wr_word[15:8];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < int'(CFG_REGS); j++) begin
      if (!rst_n || restore) begin
        cfg_q[j] <= cfg_default(j);
      end else if (wr_en && wr_idx == WIW'(ADDR_WORDS + j)) begin
        cfg_q[j] <= wr_word;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     sum_q <= '0;
    else if (wr_en) sum_q <= sum_q + wr_word[7:0] + wr_word[15:8];
  end

  assign station = station_q;
  assign cfg     = cfg_q;
  assign sum     = sum_q;
endmodule

// File: rtl/eel_hostif.sv
module eel_hostif #(
  parameter int unsigned ADDR_BYTES = 16,
  parameter int unsigned CFG_REGS   = 33,
  parameter int unsigned HAW        = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       busy,
  input  logic                       read_flag,
  input  logic                       valid_flag,
  input  logic                       req,
  input  logic                       wr,
  input  logic [HAW-1:0]             addr,
  input  logic [15:0]                wdata,
  input  logic [ADDR_BYTES-1:0][7:0] station,
  input  logic [CFG_REGS-1:0][15:0]  cfg,
  input  logic                       eng_cs,
  input  logic                       eng_sk,
  input  logic                       eng_di,
  input  logic                       pin_do,
  output logic                       devsel,
  output logic                       trdy,
  output logic                       stop,
  output logic [15:0]                rdata,
  output logic                       pin_cs,
  output logic                       pin_sk,
  output logic                       pin_di
);
  import eel_pkg::*;

  localparam logic [HAW-1:0] CTRL_ADDR = HAW'((1 << HAW) - 1);

  logic        en_q, cs_q, sk_q, di_q;
  logic        devsel_q, trdy_q, stop_q;
  logic [15:0] rdata_q;
  logic [15:0] rd_val;
  logic [15:0] ctrl_word;
  logic        accept;

  assign accept = req && !busy;

  always_comb begin
    ctrl_word           = '0;
    ctrl_word[CB_CS]    = cs_q;
    ctrl_word[CB_SK]    = sk_q;
    ctrl_word[CB_DI]    = di_q;
    ctrl_word[CB_DO]    = pin_do;
    ctrl_word[CB_EN]    = en_q;
    ctrl_word[CB_READ]  = read_flag;
    ctrl_word[CB_VALID] = valid_flag;
  end

  always_comb begin
    rd_val = '0;
    for (int b = 0; b < int'(ADDR_BYTES); b++) begin
      if (addr == HAW'(b)) rd_val = {8'h00, station[b]};
    end
    for (int j = 0; j < int'(CFG_REGS); j++) begin
      if (addr == HAW'(ADDR_BYTES + j)) rd_val = cfg[j];
    end
    if (addr == CTRL_ADDR) rd_val = ctrl_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      devsel_q <= 1'b0;
      trdy_q   <= 1'b0;
      stop_q   <= 1'b0;
      rdata_q  <= '0;
      en_q     <= 1'b0;
      cs_q     <= 1'b0;
      sk_q     <= 1'b0;
      di_q     <= 1'b0;
    end else begin
      devsel_q <= req;
      stop_q   <= req && busy;
      trdy_q   <= accept;
      if (accept) rdata_q <= rd_val;
      if (accept && wr && addr == CTRL_ADDR) begin
        en_q <= wdata[CB_EN];
        cs_q <= wdata[CB_CS];
        sk_q <= wdata[CB_SK];
        di_q <= wdata[CB_DI];
      end
    end
  end

  assign devsel = devsel_q;
  assign trdy   = trdy_q;
  assign stop   = stop_q;
  assign rdata  = rdata_q;

  // Loader owns the pins while busy; software only when idle and enabled
  assign pin_cs = busy ? eng_cs : (en_q & cs_q);
  assign pin_sk = busy ? eng_sk : (en_q & sk_q);
  assign pin_di = busy ? eng_di : (en_q & di_q);
endmodule

// File: rtl/eel_autoload.sv
module eel_autoload #(
  parameter int unsigned IMG_BYTES  = 82,
  parameter int unsigned ADDR_BYTES = 16,
  parameter int unsigned SK_HALF    = 2,
  parameter int unsigned EE_AW      = 6,
  parameter int unsigned HAW        = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ee_sense,
  output logic           ee_cs,
  output logic           ee_sk,
  output logic           ee_di,
  input  logic           ee_do,
  input  logic           host_req,
  input  logic           host_wr,
  input  logic [HAW-1:0] host_addr,
  input  logic [15:0]    host_wdata,
  output logic           host_devsel,
  output logic           host_trdy,
  output logic           host_stop,
  output logic [15:0]    host_rdata,
  output logic           ld_busy,
  output logic           ld_read,
  output logic           ld_valid
);
  import eel_pkg::*;

  localparam int unsigned WORDS    = IMG_BYTES / 2;
  localparam int unsigned CFG_REGS = WORDS - ADDR_BYTES / 2;
  localparam int unsigned WIW      = $clog2(WORDS);

  ld_state_e                  state_q;
  logic                       present_q;
  logic [WIW-1:0]             word_q;
  logic                       read_q, valid_q;
  logic                       eng_start, eng_done;
  logic                       eng_cs, eng_sk, eng_di;
  logic [15:0]                eng_word;
  logic [EE_AW-1:0]           eng_addr;
  logic                       last_word;
  logic                       restore;
  logic                       busy;
  logic [7:0]                 sum;
  logic [ADDR_BYTES-1:0][7:0] station;
  logic [CFG_REGS-1:0][15:0]  cfg_regs;

  // Presence sense: the value held at the final reset edge survives
  always_ff @(posedge clk) begin
    if (!rst_n) present_q <= ee_sense;
  end

  assign last_word = (word_q == WIW'(WORDS - 1));
  assign eng_start = (state_q == LD_BOOT && present_q) ||
                     (state_q == LD_LOAD && eng_done && !last_word);
  assign eng_addr  = (state_q == LD_LOAD) ? EE_AW'(word_q + 1'b1) : '0;
  assign restore   = (state_q == LD_CHECK) && (sum != 8'hFF);
  assign busy      = (state_q != LD_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LD_BOOT;
      word_q  <= '0;
      read_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      case (state_q)
        LD_BOOT: begin
          read_q  <= 1'b0;
          valid_q <= 1'b0;
          state_q <= present_q ? LD_LOAD : LD_IDLE;
        end
        LD_LOAD: begin
          if (eng_done) begin
            if (last_word) state_q <= LD_CHECK;
            else           word_q  <= word_q + 1'b1;
          end
        end
        LD_CHECK: begin
          read_q  <= 1'b1;
          valid_q <= (sum == 8'hFF);
          state_q <= LD_IDLE;
        end
        default: state_q <= LD_IDLE;
      endcase
    end
  end

  eel_serial #(
    .SK_HALF (SK_HALF),
    .AW      (EE_AW),
    .DW      (16)
  ) u_serial (
    .clk   (clk),
    .rst_n (rst_n),
    .start (eng_start),
    .addr  (eng_addr),
    .sdo   (ee_do),
    .sk    (eng_sk),
    .cs    (eng_cs),
    .sdi   (eng_di),
    .done  (eng_done),
    .word  (eng_word)
  );

  eel_image #(
    .ADDR_BYTES (ADDR_BYTES),
    .CFG_REGS   (CFG_REGS),
    .WIW        (WIW)
  ) u_image (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (eng_done && state_q == LD_LOAD),
    .wr_idx  (word_q),
    .wr_word (eng_word),
    .restore (restore),
    .station (station),
    .cfg     (cfg_regs),
    .sum     (sum)
  );

  eel_hostif #(
    .ADDR_BYTES (ADDR_BYTES),
    .CFG_REGS   (CFG_REGS),
    .HAW        (HAW)
  ) u_host (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .read_flag  (read_q),
    .valid_flag (valid_q),
    .req        (host_req),
    .wr         (host_wr),
    .addr       (host_addr),
    .wdata      (host_wdata),
    .station    (station),
    .cfg        (cfg_regs),
    .eng_cs     (eng_cs),
    .eng_sk     (eng_sk),
    .eng_di     (eng_di),
    .pin_do     (ee_do),
    .devsel     (host_devsel),
    .trdy       (host_trdy),
    .stop       (host_stop),
    .rdata      (host_rdata),
    .pin_cs     (ee_cs),
    .pin_sk     (ee_sk),
    .pin_di     (ee_di)
  );

  assign ld_busy  = busy;
  assign ld_read  = read_q;
  assign ld_valid = valid_q;
endmodule

// File: rtl/eel_autoload_chk.sv
module eel_autoload_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_req,
  input logic        ld_busy,
  input logic        ld_read,
  input logic        ld_valid,
  input logic        host_devsel,
  input logic        host_trdy,
  input logic        host_stop,
  input logic [15:0] cfg0
);
  import eel_pkg::*;

  AST_RETRY_WHILE_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && ld_busy |=> host_devsel && host_stop && !host_trdy); // R7

  AST_COMPLETE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    host_req && !ld_busy |=> host_devsel && host_trdy && !host_stop); // R8

  AST_NO_CLAIM_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !host_req |=> !host_devsel); // R8

  AST_VALID_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> ld_read); // R5

  AST_FLAGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_busy |=> $stable(ld_read) && $stable(ld_valid)); // R5

  AST_FAIL_RESTORES_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ld_read) && !ld_valid |-> cfg0 == cfg_default(0)); // R6
endmodule

bind eel_autoload eel_autoload_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_req    (host_req),
  .ld_busy     (ld_busy),
  .ld_read     (ld_read),
  .ld_valid    (ld_valid),
  .host_devsel (host_devsel),
  .host_trdy   (host_trdy),
  .host_stop   (host_stop),
  .cfg0        (cfg_regs[0])
);

// File: tb/eel_autoload_bench.sv
`timescale 1ns/1ps
module eel_autoload_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ee_sense = 1'b0;
  logic        ee_cs, ee_sk, ee_di;
  logic        do_drv = 1'b0;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic [6:0]  host_addr = '0;
  logic [15:0] host_wdata = '0;
  logic        host_devsel, host_trdy, host_stop;
  logic [15:0] host_rdata;
  logic        ld_busy, ld_read, ld_valid;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  eel_autoload u_eel_autoload (
    .clk(clk), .rst_n(rst_n), .ee_sense(ee_sense),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(do_drv),
    .host_req(host_req), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_devsel(host_devsel), .host_trdy(host_trdy),
    .host_stop(host_stop), .host_rdata(host_rdata),
    .ld_busy(ld_busy), .ld_read(ld_read), .ld_valid(ld_valid)
  );

  // EEPROM model
  logic [15:0] img [64];
  logic [8:0]  mcmd = '0;
  int          mcnt = 0;
  logic [8:0]  cmd_log [64];
  int          ncmd = 0;
  int          ncs = 0;
  time         t_r0 = 0, t_r1 = 0;

  always @(posedge ee_sk) begin
    if (ee_cs) begin
      if (mcnt == 0) t_r0 = $time;
      if (mcnt == 1) t_r1 = $time;
      if (mcnt < 9) mcmd = {mcmd[7:0], ee_di};
      mcnt = mcnt + 1;
    end
  end

  always @(negedge ee_sk) begin
    if (ee_cs && mcnt >= 9 && mcnt < 25) do_drv = img[mcmd[5:0]][24 - mcnt];
  end

  always @(posedge ee_cs) ncs = ncs + 1;

  always @(negedge ee_cs) begin
    if (ncmd < 64) cmd_log[ncmd] = mcmd;
    ncmd = ncmd + 1;
    mcnt = 0;
    do_drv = 1'b0;
  end

  // image bytes b(i) = 7i+3; last byte makes the sum FFh unless corrupted
  task automatic build_image(input bit bad);
    logic [7:0] b [82];
    logic [7:0] s;
    s = 8'h00;
    for (int i = 0; i < 81; i++) begin
      b[i] = 8'(7 * i + 3);
      s = s + b[i];
    end
    b[81] = 8'hFF - s + (bad ? 8'h01 : 8'h00);
    for (int k = 0; k < 64; k++) img[k] = '0;
    for (int k = 0; k < 41; k++) img[k] = {b[2*k+1], b[2*k]};
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic early, input logic last_val);
    @(negedge clk);
    rst_n = 1'b0;
    ee_sense = early;
    repeat (4) @(negedge clk);
    ee_sense = last_val;
    @(negedge clk);
    rst_n = 1'b1;
    ee_sense = 1'b0;
  endtask

  task automatic host_op(input logic wr, input logic [6:0] a, input logic [15:0] d);
    @(negedge clk);
    host_req = 1'b1;
    host_wr = wr;
    host_addr = a;
    host_wdata = d;
    @(negedge clk);
    host_req = 1'b0;
    host_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000 && ld_busy; i++) @(negedge clk);
  endtask

  // {address, expected read data} for the passing image
  localparam logic [22:0] TBL [8] = '{
    {7'd0,  16'h0003},
    {7'd5,  16'h0026},
    {7'd15, 16'h006C},
    {7'd16, 16'h7A73},
    {7'd21, 16'hC0B9},
    {7'd47, 16'h2C25},
    {7'd48, 16'h7433},
    {7'd49, 16'h0000}
  };

  initial begin
    #800000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // Reset state
    repeat (3) @(negedge clk);
    chk("R8 reset devsel", {31'd0, host_devsel}, 32'd0);
    chk("R5 reset flags", {30'd0, ld_read, ld_valid}, 32'd0);

    // Passing image; sense low early, high only in the last reset cycle
    build_image(1'b0);
    ncmd = 0;
    do_reset(1'b0, 1'b1);
    @(negedge clk);
    chk("R1 busy after present", {31'd0, ld_busy}, 32'd1);
    chk("R1 cs after present", {31'd0, ee_cs}, 32'd1);
    host_op(1'b0, 7'd0, 16'h0);
    chk("R7 retry response", {29'd0, host_devsel, host_trdy, host_stop}, 32'b101);
    wait_idle();
    chk("R5 read flag", {31'd0, ld_read}, 32'd1);
    chk("R5 valid flag", {31'd0, ld_valid}, 32'd1);
    chk("R2 command count", ncmd, 32'd41);
    chk("R2 first command", {23'd0, cmd_log[0]}, 32'h180);
    chk("R2 last command", {23'd0, cmd_log[40]}, 32'h1A8);
    chk("R3 sk period ns", 32'(t_r1 - t_r0), 32'd16);
    for (int i = 0; i < 8; i++) begin
      host_op(1'b0, TBL[i][22:16], 16'h0);
      chk("R4 table read", {16'd0, host_rdata}, {16'd0, TBL[i][15:0]});
      chk("R8 table response", {29'd0, host_devsel, host_trdy, host_stop}, 32'b110);
    end
    @(negedge clk);
    chk("R8 idle no claim", {31'd0, host_devsel}, 32'd0);
    host_op(1'b0, 7'h7F, 16'h0);
    chk("R9 ctrl after pass", {16'd0, host_rdata}, 32'hC000);

    // Direct pin control
    host_op(1'b1, 7'h7F, 16'h0016);
    chk("R9 pins enabled", {29'd0, ee_cs, ee_sk, ee_di}, 32'b011);
    do_drv = 1'b1;
    host_op(1'b0, 7'h7F, 16'h0);
    chk("R9 ctrl readback", {16'd0, host_rdata}, 32'hC01E);
    host_op(1'b1, 7'h7F, 16'h0007);
    chk("R9 pins disabled", {29'd0, ee_cs, ee_sk, ee_di}, 32'b000);
    do_drv = 1'b0;

    // Failing checksum
    build_image(1'b1);
    do_reset(1'b1, 1'b1);
    repeat (3) @(negedge clk);
    host_op(1'b1, 7'h7F, 16'h0017);
    chk("R7 write retried", {29'd0, host_devsel, host_trdy, host_stop}, 32'b101);
    wait_idle();
    chk("R6 read flag", {31'd0, ld_read}, 32'd1);
    chk("R6 valid flag", {31'd0, ld_valid}, 32'd0);
    host_op(1'b0, 7'd16, 16'h0);
    chk("R6 cfg0 default", {16'd0, host_rdata}, 32'h5A00);
    host_op(1'b0, 7'd48, 16'h0);
    chk("R6 cfg32 default", {16'd0, host_rdata}, 32'h5A20);
    host_op(1'b0, 7'd5, 16'h0);
    chk("R6 station kept", {16'd0, host_rdata}, 32'h0026);
    host_op(1'b0, 7'h7F, 16'h0);
    chk("R9 write during load ignored", {16'd0, host_rdata}, 32'h4000);
    chk("R9 pins idle", {29'd0, ee_cs, ee_sk, ee_di}, 32'b000);

    // No EEPROM: sense high early, low in the last reset cycle
    ncs = 0;
    do_reset(1'b1, 1'b0);
    @(negedge clk);
    chk("R1 busy absent", {31'd0, ld_busy}, 32'd0);
    chk("R1 flags absent", {30'd0, ld_read, ld_valid}, 32'd0);
    host_op(1'b0, 7'd16, 16'h0);
    chk("R10 cfg0 default", {16'd0, host_rdata}, 32'h5A00);
    host_op(1'b0, 7'd40, 16'h0);
    chk("R10 cfg24 default", {16'd0, host_rdata}, 32'h5A18);
    repeat (20) @(negedge clk);
    chk("R1 no chip select", ncs, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule